// File: doc/BRIEF.md
# Pipelined AES-128 Cipher and Inverse Cipher Datapath

This block is a fully pipelined AES-128 datapath that runs either direction on a per-block basis. A 128-bit block enters together with a valid flag and a direction bit. It first passes through a key-addition stage, then through ten round stages. Each round stage holds sixteen byte-substitution units, and each unit contains one multiplicative-inverse circuit that serves both directions. Multiplexers steered by the block's own direction bit put the affine map after the inverse when encrypting, and the inverse affine map before it when decrypting. They also decide whether the row rotation comes before or after substitution, and which column mix is applied.

The direction bit and the valid flag are registered alongside the data in every stage, so encrypt and decrypt blocks may be interleaved freely. A block may be offered on every clock. Each result leaves exactly eleven cycles later, and a stream of inputs gives a stream of outputs on consecutive cycles. Key expansion is done elsewhere. The eleven round keys arrive on one wide port that must stay stable while blocks are in flight, and they are already arranged for the direction in use. For decryption the round order is the equivalent inverse cipher, with column mixing ahead of key addition. This means the middle nine decryption keys must already have the inverse column mix applied.

Top module: `aes_pipe_core`

## Requirements
- R1: A block taken with in_valid_i high at a rising edge shows out_valid_o high, with its result on out_block_o, after exactly 11 rising edges. out_valid_o is never high earlier for that block.
- R2: A block is accepted on every clock edge with in_valid_i high, with no stall. N consecutive input blocks yield N results on N consecutive cycles, in the same order.
- R3: With in_dec_i = 0 the block is encrypted. The steps are key 0 addition, then nine rounds of substitution (inverse then affine), row rotation, column mix and key addition, then a final round with no column mix. The FIPS-197 AES-128 vectors must give the published ciphertexts.
- R4: With in_dec_i = 1 the block is decrypted. The steps are key 0 addition, then nine rounds of inverse row rotation, inverse substitution (inverse affine then inverse), inverse column mix and key addition, then a final round with no inverse column mix. Keys are given as: slot 0 = last encryption key, slot i = inverse column mix of encryption key 10-i for i = 1..9, slot 10 = encryption key 0. This must recover the published plaintexts.
- R5: The direction is taken per block and travels with it, so alternating encrypt and decrypt blocks back to back each get their own direction's transform.
- R6: A cycle with in_valid_i low gives out_valid_o low 11 cycles later. out_block_o then keeps the most recent result unchanged.
- R7: While rst_ni is low, out_valid_o is low whatever the inputs are. After release it stays low until a valid block has had time to pass through.
- R8: Round key k sits at round_keys_i[128*k+127 : 128*k], and key 0 is used first. State byte 0 is bits [127:120], and bytes fill the state column by column (byte r+4c is row r, column c).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input block is valid this cycle |
| in_dec_i | input | 1 | Direction of this block: 0 encrypt, 1 decrypt |
| in_block_i | input | 128 | Input data block |
| round_keys_i | input | 1408 | Eleven round keys, key k at bits [128k+127:128k] |
| out_valid_o | output | 1 | Result block is valid this cycle |
| out_block_o | output | 128 | Result data block |

## Verification
The published vectors are run in both directions. A wrong affine constant, a swapped rotation direction or a column mix left in the last round would turn every ciphertext and plaintext into garbage. Alternating-direction streams of sixteen back-to-back blocks are aimed at a design that latches the direction once instead of per stage: the first block of the other direction would come out wrong, as would every block that follows one. A pattern with idle gaps, checked cycle by cycle, catches a pipeline that is one stage short or long. That fault would put results one cycle off, let idle slots raise out_valid_o, or disturb the held output. Reset is held with a valid input asserted, to catch a valid flag that leaks through during reset.

// File: rtl/aes_pipe_pkg.sv
`timescale 1ns/1ps
package aes_pipe_pkg;
  localparam int unsigned BLK_W = 128;
  localparam int unsigned NB    = BLK_W / 8;

  typedef logic [7:0]       byte_t;
  typedef logic [BLK_W-1:0] blk_t;

  function automatic byte_t gf_xtime(byte_t a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic byte_t gf_mul(byte_t a, byte_t b);
    byte_t acc = '0;
    byte_t t   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ t;
      t = gf_xtime(t);
    end
    return acc;
  endfunction

  // a^254 = a^2 * a^4 * ... * a^128; maps 0 to 0
  function automatic byte_t gf_inv(byte_t a);
    byte_t r  = 8'h01;
    byte_t sq = a;
    for (int i = 1; i < 8; i++) begin
      sq = gf_mul(sq, sq);
      r  = gf_mul(r, sq);
    end
    return r;
  endfunction

  function automatic byte_t rotl8(byte_t b, int unsigned n);
    byte_t v = b;
    for (int unsigned i = 0; i < n; i++) v = {v[6:0], v[7]};
    return v;
  endfunction

  function automatic byte_t affine_fwd(byte_t b);
    return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
  endfunction

  function automatic byte_t affine_inv(byte_t b);
    return rotl8(b, 1) ^ rotl8(b, 3) ^ rotl8(b, 6) ^ 8'h05;
  endfunction

  // byte r+4c is row r, column c; byte 0 in the top bits
  function automatic blk_t shift_rows(blk_t s, logic inv);
    blk_t o = '0;
    int   src;
    for (int c = 0; c < 4; c++) begin
      for (int r = 0; r < 4; r++) begin
        src = inv ? ((c + 4 - r) % 4) : ((c + r) % 4);
        o[BLK_W-1-8*(r+4*c) -: 8] = s[BLK_W-1-8*(r+4*src) -: 8];
      end
    end
    return o;
  endfunction

  function automatic logic [31:0] mix_col(logic [31:0] w, logic inv);
    byte_t       m [4];
    byte_t       a [4];
    byte_t       acc;
    logic [31:0] o = '0;
    if (inv) begin
      m[0] = 8'h0e; m[1] = 8'h0b; m[2] = 8'h0d; m[3] = 8'h09;
    end else begin
      m[0] = 8'h02; m[1] = 8'h03; m[2] = 8'h01; m[3] = 8'h01;
    end
    for (int k = 0; k < 4; k++) a[k] = w[31-8*k -: 8];
    for (int r = 0; r < 4; r++) begin
      acc = '0;
      for (int k = 0; k < 4; k++) acc = acc ^ gf_mul(a[k], m[(k + 4 - r) % 4]);
      o[31-8*r -: 8] = acc;
    end
    return o;
  endfunction

  function automatic blk_t mix_cols(blk_t s, logic inv);
    blk_t o = '0;
    for (int c = 0; c < 4; c++) o[BLK_W-1-32*c -: 32] = mix_col(s[BLK_W-1-32*c -: 32], inv);
    return o;
  endfunction
endpackage

// File: rtl/aes_sub_byte.sv
`timescale 1ns/1ps
module aes_sub_byte
  import aes_pipe_pkg::*;
(
  input  byte_t byte_i,
  input  logic  dec_i,
  output byte_t byte_o
);
  byte_t pre_inv;
  byte_t inv_b;

  // one inverse shared by both directions; affine maps placed around it
  always_comb begin
    pre_inv = dec_i ? affine_inv(byte_i) : byte_i;
    inv_b   = gf_inv(pre_inv);
    byte_o  = dec_i ? inv_b : affine_fwd(inv_b);
  end

  always_comb begin
    p_no_fixed_point_r3: assert ((byte_o != byte_i) && (byte_o != ~byte_i));
    if (dec_i) begin
      p_affine_pair_r4: assert (affine_fwd(pre_inv) == byte_i);
    end
  end
endmodule

// File: rtl/aes_round_stage.sv
`timescale 1ns/1ps
module aes_round_stage
  import aes_pipe_pkg::*;
#(
  parameter bit LAST = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic dec_i,
  input  blk_t state_i,
  input  blk_t rkey_i,
  output logic valid_o,
  output logic dec_o,
  output blk_t state_o
);
  blk_t pre_sub, post_sub, post_shift, post_mix;

  assign pre_sub = dec_i ? shift_rows(state_i, 1'b1) : state_i;

  for (genvar b = 0; b < NB; b++) begin : g_sub
    aes_sub_byte u_sub (
      .byte_i(pre_sub[BLK_W-1-8*b -: 8]),
      .dec_i (dec_i),
      .byte_o(post_sub[BLK_W-1-8*b -: 8])
    );
  end

  assign post_shift = dec_i ? post_sub : shift_rows(post_sub, 1'b0);

  if (LAST) begin : g_last
    assign post_mix = post_shift;
  end else begin : g_mid
    assign post_mix = mix_cols(post_shift, dec_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      dec_o   <= 1'b0;
      state_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        dec_o   <= dec_i;
        state_o <= post_mix ^ rkey_i;
      end
    end
  end

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(state_o));
endmodule

// File: rtl/aes_pipe_core.sv
`timescale 1ns/1ps
module aes_pipe_core
  import aes_pipe_pkg::*;
#(
  parameter int unsigned NUM_ROUNDS = 10
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                in_valid_i,
  input  logic                                in_dec_i,
  input  logic [BLK_W-1:0]                    in_block_i,
  input  logic [(NUM_ROUNDS+1)*BLK_W-1:0]     round_keys_i,
  output logic                                out_valid_o,
  output logic [BLK_W-1:0]                    out_block_o
);
  localparam int unsigned NKEYS = NUM_ROUNDS + 1;
  localparam int unsigned LAT   = NKEYS;

  logic vld [NKEYS];
  logic dec [NKEYS];
  blk_t st  [NKEYS];

  // stage 0: initial key addition
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld[0] <= 1'b0;
      dec[0] <= 1'b0;
      st[0]  <= '0;
    end else begin
      vld[0] <= in_valid_i;
      if (in_valid_i) begin
        dec[0] <= in_dec_i;
        st[0]  <= in_block_i ^ round_keys_i[0 +: BLK_W];
      end
    end
  end

  for (genvar r = 1; r <= NUM_ROUNDS; r++) begin : g_round
    aes_round_stage #(.LAST(r == NUM_ROUNDS)) u_round (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .valid_i(vld[r-1]),
      .dec_i  (dec[r-1]),
      .state_i(st[r-1]),
      .rkey_i (round_keys_i[r*BLK_W +: BLK_W]),
      .valid_o(vld[r]),
      .dec_o  (dec[r]),
      .state_o(st[r])
    );
  end

  assign out_valid_o = vld[NUM_ROUNDS];
  assign out_block_o = st[NUM_ROUNDS];

  // checker history of accepted slots
  logic [LAT-1:0] vhist, mhist;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vhist <= '0;
      mhist <= '0;
    end else begin
      vhist <= {vhist[LAT-2:0], in_valid_i};
      mhist <= {mhist[LAT-2:0], in_dec_i};
    end
  end

  p_latency_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o == vhist[LAT-1]);

  p_mode_travel_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (dec[NUM_ROUNDS] == mhist[LAT-1]));
endmodule

// File: tb/aes_pipe_core_bench.sv
`timescale 1ns/1ps
module aes_pipe_core_bench;
  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_dec = 1'b0;
  logic [127:0]  in_block = '0;
  logic [1407:0] keys = '0;
  logic          out_valid;
  logic [127:0]  out_block;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  aes_pipe_core u_aes_pipe_core (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .in_valid_i  (in_valid),
    .in_dec_i    (in_dec),
    .in_block_i  (in_block),
    .round_keys_i(keys),
    .out_valid_o (out_valid),
    .out_block_o (out_block)
  );

  logic [7:0]   tbl_s  [256];
  logic [7:0]   tbl_is [256];
  logic [127:0] ek [11];
  logic [127:0] dk [11];

  logic         s_v [32];
  logic         s_d [32];
  logic [127:0] s_b [32];
  logic [127:0] s_e [32];

  // ---------------- reference model ----------------
  function automatic logic [7:0] rl(logic [7:0] b, int n);
    logic [7:0] v = b;
    for (int i = 0; i < n; i++) v = {v[6:0], v[7]};
    return v;
  endfunction

  function automatic logic [7:0] xt(logic [7:0] a);
    return a[7] ? ({a[6:0], 1'b0} ^ 8'h1b) : {a[6:0], 1'b0};
  endfunction

  function automatic logic [7:0] mulb(logic [7:0] a, logic [7:0] b);
    logic [7:0] p = '0;
    logic [7:0] t = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ t;
      t = xt(t);
    end
    return p;
  endfunction

  function automatic logic [127:0] sub_all(logic [127:0] s, bit inv);
    logic [127:0] o;
    for (int i = 0; i < 16; i++)
      o[127-8*i -: 8] = inv ? tbl_is[s[127-8*i -: 8]] : tbl_s[s[127-8*i -: 8]];
    return o;
  endfunction

  function automatic logic [127:0] shr(logic [127:0] s, bit inv);
    logic [127:0] o;
    int src;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++) begin
        src = inv ? (c - r + 4) % 4 : (c + r) % 4;
        o[127-8*(4*c+r) -: 8] = s[127-8*(4*src+r) -: 8];
      end
    return o;
  endfunction

  function automatic logic [127:0] mixall(logic [127:0] s, bit inv);
    logic [127:0] o;
    logic [7:0] a0, a1, a2, a3, c0, c1, c2, c3;
    c0 = inv ? 8'h0e : 8'h02; c1 = inv ? 8'h0b : 8'h03;
    c2 = inv ? 8'h0d : 8'h01; c3 = inv ? 8'h09 : 8'h01;
    for (int c = 0; c < 4; c++) begin
      a0 = s[127-32*c -: 8];  a1 = s[119-32*c -: 8];
      a2 = s[111-32*c -: 8];  a3 = s[103-32*c -: 8];
      o[127-32*c -: 8] = mulb(a0,c0) ^ mulb(a1,c1) ^ mulb(a2,c2) ^ mulb(a3,c3);
      o[119-32*c -: 8] = mulb(a0,c3) ^ mulb(a1,c0) ^ mulb(a2,c1) ^ mulb(a3,c2);
      o[111-32*c -: 8] = mulb(a0,c2) ^ mulb(a1,c3) ^ mulb(a2,c0) ^ mulb(a3,c1);
      o[103-32*c -: 8] = mulb(a0,c1) ^ mulb(a1,c2) ^ mulb(a2,c3) ^ mulb(a3,c0);
    end
    return o;
  endfunction

  function automatic logic [127:0] model(logic [127:0] blk, bit dec, logic [1407:0] k);
    logic [127:0] s = blk ^ k[127:0];
    for (int r = 1; r <= 10; r++) begin
      if (!dec) s = shr(sub_all(s, 1'b0), 1'b0);
      else      s = sub_all(shr(s, 1'b1), 1'b1);
      if (r < 10) s = mixall(s, dec);
      s = s ^ k[128*r +: 128];
    end
    return s;
  endfunction

  function automatic logic [1407:0] pack(logic [127:0] k [11]);
    logic [1407:0] v;
    for (int i = 0; i < 11; i++) v[128*i +: 128] = k[i];
    return v;
  endfunction

  task automatic build_sbox();
    logic [7:0] p, q, x;
    p = 8'h01; q = 8'h01;
    tbl_s[0] = 8'h63;
    do begin
      p = p ^ {p[6:0], 1'b0} ^ (p[7] ? 8'h1b : 8'h00);
      q = q ^ {q[6:0], 1'b0};
      q = q ^ {q[5:0], 2'b00};
      q = q ^ {q[3:0], 4'h0};
      if (q[7]) q = q ^ 8'h09;
      x = q ^ rl(q,1) ^ rl(q,2) ^ rl(q,3) ^ rl(q,4);
      tbl_s[p] = x ^ 8'h63;
    end while (p != 8'h01);
    for (int i = 0; i < 256; i++) tbl_is[tbl_s[i]] = 8'(i);
  endtask

  task automatic expand(logic [127:0] key);
    logic [31:0] w [44];
    logic [31:0] t;
    logic [7:0]  rc;
    rc = 8'h01;
    for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      t = w[i-1];
      if (i % 4 == 0) begin
        t = {t[23:0], t[31:24]};
        t = {tbl_s[t[31:24]], tbl_s[t[23:16]], tbl_s[t[15:8]], tbl_s[t[7:0]]} ^ {rc, 24'h0};
        rc = xt(rc);
      end
      w[i] = w[i-4] ^ t;
    end
    for (int r = 0; r < 11; r++) ek[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
    dk[0]  = ek[10];
    dk[10] = ek[0];
    for (int r = 1; r < 10; r++) dk[r] = mixall(ek[10-r], 1'b1);
  endtask

  // ---------------- checks ----------------
  task automatic check_blk(string req, logic [127:0] act, logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s block act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic check_bit(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s valid act=%b exp=%b", req, act, exp);
    end
  endtask

  // slot t driven at negedge t; its result is visible at negedge t+11
  task automatic run_seq(int n, string req);
    logic [127:0] hold;
    for (int t = 0; t < n + 11; t++) begin
      @(negedge clk);
      if (t == 0) hold = out_block;
      if (t < 11) begin
        check_bit({req, " R1 early"}, out_valid, 1'b0);
      end else begin
        check_bit({req, " R1"}, out_valid, s_v[t-11]);
        if (s_v[t-11]) begin
          check_blk(req, out_block, s_e[t-11]);
          hold = s_e[t-11];
        end else begin
          check_blk({req, " R6 hold"}, out_block, hold);
        end
      end
      if (t < n) begin
        in_valid = s_v[t]; in_dec = s_d[t]; in_block = s_b[t];
      end else begin
        in_valid = 1'b0; in_dec = 1'b0; in_block = '0;
      end
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b1; in_block = 128'h1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check_bit("R7 in reset", out_valid, 1'b0);
    end
    in_valid = 1'b0;
    rst_n = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      check_bit("R7 after release", out_valid, 1'b0);
    end
  endtask

  task automatic t_enc_vec();
    expand(128'h000102030405060708090a0b0c0d0e0f);
    keys = pack(ek);
    s_v[0] = 1'b1; s_d[0] = 1'b0;
    s_b[0] = 128'h00112233445566778899aabbccddeeff;
    s_e[0] = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
    run_seq(1, "R3 R8 vec1");
    expand(128'h2b7e151628aed2a6abf7158809cf4f3c);
    keys = pack(ek);
    s_b[0] = 128'h3243f6a8885a308d313198a2e0370734;
    s_e[0] = 128'h3925841d02dc09fbdc118597196a0b32;
    run_seq(1, "R3 R8 vec2");
  endtask

  task automatic t_dec_vec();
    logic [1407:0] ekp;
    expand(128'h000102030405060708090a0b0c0d0e0f);
    keys = pack(dk);
    s_v[0] = 1'b1; s_d[0] = 1'b1;
    s_b[0] = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
    s_e[0] = 128'h00112233445566778899aabbccddeeff;
    run_seq(1, "R4 vec1");
    expand(128'h2b7e151628aed2a6abf7158809cf4f3c);
    ekp = pack(ek);
    keys = pack(dk);
    for (int i = 0; i < 6; i++) begin
      s_v[i] = 1'b1; s_d[i] = 1'b1;
      s_e[i] = {4{32'h9e3779b9 * (i + 3)}};
      s_b[i] = model(s_e[i], 1'b0, ekp);
    end
    s_b[0] = 128'h3925841d02dc09fbdc118597196a0b32;
    s_e[0] = 128'h3243f6a8885a308d313198a2e0370734;
    run_seq(6, "R4 R2 dec stream");
  endtask

  task automatic t_stream();
    expand(128'h000102030405060708090a0b0c0d0e0f);
    keys = pack(ek);
    for (int i = 0; i < 16; i++) begin
      s_v[i] = 1'b1;
      s_d[i] = i[0];
      s_b[i] = {32'h01234567 * (i + 1), 32'hdeadbeef ^ i, 32'h5a5a0000 + i, 32'hc001d00d * i};
      s_e[i] = model(s_b[i], s_d[i], keys);
    end
    run_seq(16, "R5 R2 alternating");
  endtask

  task automatic t_gaps();
    expand(128'h2b7e151628aed2a6abf7158809cf4f3c);
    keys = pack(ek);
    for (int i = 0; i < 12; i++) begin
      s_v[i] = (i % 3 != 1) && (i != 7);
      s_d[i] = (i > 5);
      s_b[i] = {4{32'h13579bdf + 32'(i)}};
      s_e[i] = model(s_b[i], s_d[i], keys);
    end
    run_seq(12, "R6 R1 gaps");
  endtask

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    build_sbox();
    t_reset();
    t_enc_vec();
    t_dec_vec();
    t_stream();
    t_gaps();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule